// File: doc/BRIEF.md
# Dual Shift-Right Pack Execution Unit

This execution unit belongs to a 32-bit media extension. It decodes two instruction variants from a 32-bit instruction word. Each variant takes two 32-bit operands from a 16-entry extension register file and shifts both of them arithmetically right by the same 4-bit amount. It then joins the low 16 bits of the two results into a single 32-bit word and writes that word back to the file. In one variant the amount comes from an immediate field in the instruction. In the other it comes from the low bits of a general-purpose register, which the unit addresses on an output port and reads back on an input port in the same cycle.

The unit owns the extension register file. Entry 0 always reads as zero. Other extension units deliver their results through a write-back port, and a combinational read port exposes the file to its consumers. A result lands in the file on the clock edge after a valid instruction strobe, and a completion pulse is raised for that cycle.

Top module: `dsrp_unit`

## Requirements
- R1: A synchronous active-high reset clears every register entry to zero and holds `done` low.
- R2: Reading index 0 returns zero at all times, including after a write-back to index 0.
- R3: An instruction whose bits 5:0 equal 0x32 is the immediate variant. Its shift amount is instruction bits 25:22, which is the 5-bit field at 25:21 halved, so bit 21 has no effect.
- R4: An instruction whose bits 5:0 equal the pool opcode (default 0x27) and whose bits 20:18 are 0 is the register variant. `gpr_raddr` carries instruction bits 25:21, and the shift amount is `gpr_rdata[3:0]`. Bits 31:4 of `gpr_rdata` have no effect.
- R5: Both operands are shifted arithmetically right, with the sign bit replicated, by the same amount in the range 0 to 15.
- R6: The result takes its bits 15:0 from the low 16 bits of the shifted operand indexed by instruction bits 17:14, and its bits 31:16 from the low 16 bits of the shifted operand indexed by bits 13:10.
- R7: The result is written to the entry indexed by instruction bits 9:6 on the clock edge that samples `instr_valid` high. `done` is high for the cycle after that edge.
- R8: A decoded instruction with destination index 0 changes no register, but `done` still pulses.
- R9: An instruction with another opcode, a pool instruction with bits 20:18 not 0, or any instruction without `instr_valid` writes nothing and raises no `done`.
- R10: The write-back port writes `wb_data` to entry `wb_idx` on the edge where `wb_en` is high. If a unit result targets the same entry in the same cycle, the unit result wins.
- R11: Operands are read from the register values present before the writing edge, so a destination equal to a source uses the old source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| gpr_raddr | output | 5 | General-purpose register read address |
| gpr_rdata | input | 32 | General-purpose register read data |
| wb_en | input | 1 | Write-back enable from other units |
| wb_idx | input | 4 | Write-back entry index |
| wb_data | input | 32 | Write-back data |
| xr_raddr | input | 4 | Read-port entry index |
| xr_rdata | output | 32 | Read-port data |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the unit with its default parameters: 32-bit data, sixteen entries, immediate opcode 0x32 and pool opcode 0x27. With these values a single 4-bit amount exercises every lane boundary. The bench drives the amounts 0 and 15 and operands with both sign polarities. It also covers the corner cases of a destination equal to a source, a destination of index 0, and a write-back collision on the same entry.

// File: rtl/dsrp_pkg.sv
package dsrp_pkg;
    localparam int INSTR_W = 32;
    localparam int IDX_W   = 4;
    localparam int FLD_W   = 5;
    localparam int AMT_W   = 4;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_IMM  = 2'd1,
        OPK_REG  = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src_hi;
        logic [IDX_W-1:0] src_lo;
        logic [FLD_W-1:0] fld;
    } dec_t;
endpackage

// File: rtl/dsrp_decode.sv
module dsrp_decode
    import dsrp_pkg::*;
#(
    parameter logic [5:0] IMM_OPC  = 6'h32,
    parameter logic [5:0] POOL_OPC = 6'h27
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [5:0] major;
    logic [2:0] minor;

    always_comb begin
        major      = instr[5:0];
        minor      = instr[20:18];
        dec.dst    = instr[9:6];
        dec.src_hi = instr[13:10];
        dec.src_lo = instr[17:14];
        dec.fld    = instr[25:21];
        if (major == IMM_OPC)
            dec.kind = OPK_IMM;
        else if (major == POOL_OPC && minor == 3'd0)
            dec.kind = OPK_REG;
        else
            dec.kind = OPK_NONE;
    end
endmodule

// File: rtl/dsrp_shpack.sv
module dsrp_shpack #(
    parameter int XLEN  = 32,
    parameter int AMT_W = 4
) (
    input  logic [XLEN-1:0]  op_hi,
    input  logic [XLEN-1:0]  op_lo,
    input  logic [AMT_W-1:0] amt,
    output logic [XLEN-1:0]  packed_res
);
    localparam int HW    = XLEN / 2;
    localparam int LANES = 2;

    logic [LANES-1:0][XLEN-1:0] lane_src;
    assign lane_src[0] = op_lo;
    assign lane_src[1] = op_hi;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [XLEN-1:0] shifted;
        assign shifted = $signed(lane_src[g]) >>> amt;
        assign packed_res[g*HW +: HW] = shifted[HW-1:0];
    end
endmodule

// File: rtl/dsrp_xregs.sv
module dsrp_xregs #(
    parameter int XLEN = 32,
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ua_en,
    input  logic [$clog2(NREG)-1:0] ua_idx,
    input  logic [XLEN-1:0]         ua_data,
    input  logic                    ub_en,
    input  logic [$clog2(NREG)-1:0] ub_idx,
    input  logic [XLEN-1:0]         ub_data,
    input  logic [$clog2(NREG)-1:0] rp0_idx,
    output logic [XLEN-1:0]         rp0_data,
    input  logic [$clog2(NREG)-1:0] rp1_idx,
    output logic [XLEN-1:0]         rp1_data,
    input  logic [$clog2(NREG)-1:0] rp2_idx,
    output logic [XLEN-1:0]         rp2_data
);
    localparam int IW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] ent;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (ub_en && ub_idx != '0)
            rf_d.ent[ub_idx] = ub_data;
        if (ua_en && ua_idx != '0)
            rf_d.ent[ua_idx] = ua_data;
        rf_d.ent[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rf_q <= '0;
        else     rf_q <= rf_d;
    end

    function automatic logic [XLEN-1:0] rd(input logic [IW-1:0] idx, input rf_t f);
        return (idx == '0) ? '0 : f.ent[idx];
    endfunction

    assign rp0_data = rd(rp0_idx, rf_q);
    assign rp1_data = rd(rp1_idx, rf_q);
    assign rp2_data = rd(rp2_idx, rf_q);
endmodule

// File: rtl/dsrp_unit.sv
module dsrp_unit
    import dsrp_pkg::*;
#(
    parameter int         XLEN     = 32,
    parameter int         NREG     = 16,
    parameter logic [5:0] IMM_OPC  = 6'h32,
    parameter logic [5:0] POOL_OPC = 6'h27
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    output logic [4:0]      gpr_raddr,
    input  logic [XLEN-1:0] gpr_rdata,
    input  logic            wb_en,
    input  logic [3:0]      wb_idx,
    input  logic [XLEN-1:0] wb_data,
    input  logic [3:0]      xr_raddr,
    output logic [XLEN-1:0] xr_rdata,
    output logic            done
);
    typedef struct packed {
        logic done;
    } ctl_t;

    dec_t             dec;
    logic [XLEN-1:0]  op_hi, op_lo, result;
    logic [AMT_W-1:0] amt;
    logic             hit, unit_we;
    ctl_t             ctl_d, ctl_q;

    dsrp_decode #(.IMM_OPC(IMM_OPC), .POOL_OPC(POOL_OPC)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    dsrp_xregs #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .ua_en    (unit_we),
        .ua_idx   (dec.dst),
        .ua_data  (result),
        .ub_en    (wb_en),
        .ub_idx   (wb_idx),
        .ub_data  (wb_data),
        .rp0_idx  (dec.src_hi),
        .rp0_data (op_hi),
        .rp1_idx  (dec.src_lo),
        .rp1_data (op_lo),
        .rp2_idx  (xr_raddr),
        .rp2_data (xr_rdata)
    );

    dsrp_shpack #(.XLEN(XLEN), .AMT_W(AMT_W)) u_sp (
        .op_hi      (op_hi),
        .op_lo      (op_lo),
        .amt        (amt),
        .packed_res (result)
    );

    assign gpr_raddr = dec.fld;

    always_comb begin
        hit     = instr_valid && (dec.kind != OPK_NONE);
        unit_we = hit && (dec.dst != '0);
        if (dec.kind == OPK_REG) amt = gpr_rdata[AMT_W-1:0];
        else                     amt = dec.fld[FLD_W-1:1];
        ctl_d.done = hit;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign done = ctl_q.done;
endmodule

// File: rtl/dsrp_unit_chk.sv
module dsrp_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            instr_valid,
    input logic            done,
    input logic            unit_we,
    input logic            wb_en,
    input logic [3:0]      xr_raddr,
    input logic [XLEN-1:0] xr_rdata
);
    p_done_follows_valid_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(instr_valid));

    p_zero_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (xr_raddr == 4'd0) |-> (xr_rdata == '0));

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !done);

    p_hold_without_write_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(unit_we) && !$past(wb_en) && $stable(xr_raddr))
        |-> $stable(xr_rdata));

    p_write_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
        unit_we |-> instr_valid);
endmodule

bind dsrp_unit dsrp_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .done        (done),
    .unit_we     (unit_we),
    .wb_en       (wb_en),
    .xr_raddr    (xr_raddr),
    .xr_rdata    (xr_rdata)
);

// File: tb/dsrp_unit_tb.sv
module dsrp_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  gpr_raddr;
    logic [31:0] gpr_rdata = '0;
    logic        wb_en = 1'b0;
    logic [3:0]  wb_idx = '0;
    logic [31:0] wb_data = '0;
    logic [3:0]  xr_raddr = '0;
    logic [31:0] xr_rdata;
    logic        done;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [16];

    localparam logic [5:0] OPC_I = 6'h32;
    localparam logic [5:0] OPC_P = 6'h27;

    dsrp_unit u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .xr_raddr(xr_raddr), .xr_rdata(xr_rdata), .done(done)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [3:0] d,
                                       input logic [3:0] a, input logic [3:0] b,
                                       input logic [2:0] mn, input logic [4:0] f);
        return {6'b0, f, mn, b, a, d, opc};
    endfunction

    function automatic logic [31:0] expect_pack(input logic [31:0] hi, input logic [31:0] lo,
                                                input int sh);
        logic signed [31:0] h, l;
        h = $signed(hi) >>> sh;
        l = $signed(lo) >>> sh;
        return {h[15:0], l[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] v);
        xr_raddr = idx;
        #1 v = xr_rdata;
    endtask

    task automatic wb(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        wb_en = 1'b1; wb_idx = idx; wb_data = d;
        @(posedge clk);
        @(negedge clk);
        wb_en = 1'b0;
        if (idx != 0) model[idx] = d;
    endtask

    task automatic issue(input logic [31:0] ins, input logic [31:0] g, output logic dn);
        @(negedge clk);
        instr = ins; instr_valid = 1'b1; gpr_rdata = g;
        @(posedge clk);
        @(negedge clk);
        dn = done;
        instr_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 done after reset", {31'b0, done}, 32'd0);
        rd(4'd5, v); chk("R1 entry5 cleared", v, 32'd0);
        rd(4'd15, v); chk("R1 entry15 cleared", v, 32'd0);
    endtask

    task automatic t_load;
        logic [31:0] v;
        wb(4'd1, 32'h8000_1234);
        wb(4'd2, 32'h7FFF_ABCD);
        wb(4'd3, 32'hFFFF_0000);
        wb(4'd0, 32'hDEAD_BEEF);
        rd(4'd1, v); chk("R10 writeback r1", v, 32'h8000_1234);
        rd(4'd3, v); chk("R10 writeback r3", v, 32'hFFFF_0000);
        rd(4'd0, v); chk("R2 entry0 reads zero", v, 32'd0);
    endtask

    task automatic t_imm;
        logic dn; logic [31:0] v, e;
        // field 01011: amount 5, bit 21 set and ignored
        issue(mk(OPC_I, 4'd4, 4'd1, 4'd2, 3'd0, 5'b01011), 32'h0, dn);
        e = expect_pack(model[1], model[2], 5);
        model[4] = e;
        chk("R7 done pulse imm", {31'b0, dn}, 32'd1);
        rd(4'd4, v); chk("R3 R5 R6 imm amount5", v, e);
        issue(mk(OPC_I, 4'd5, 4'd3, 4'd1, 3'd0, 5'b11110), 32'h0, dn);
        e = expect_pack(model[3], model[1], 15);
        model[5] = e;
        rd(4'd5, v); chk("R5 imm amount15 sign fill", v, e);
        issue(mk(OPC_I, 4'd7, 4'd2, 4'd3, 3'd0, 5'b00001), 32'h0, dn);
        e = {model[2][15:0], model[3][15:0]};
        model[7] = e;
        rd(4'd7, v); chk("R6 amount0 plain pack", v, e);
        @(negedge clk);
        chk("R7 done drops", {31'b0, done}, 32'd0);
    endtask

    task automatic t_reg;
        logic dn; logic [31:0] v, e;
        @(negedge clk);
        instr = mk(OPC_P, 4'd8, 4'd1, 4'd3, 3'd0, 5'd19);
        #1 chk("R4 gpr address", {27'b0, gpr_raddr}, 32'd19);
        issue(mk(OPC_P, 4'd8, 4'd1, 4'd3, 3'd0, 5'd19), 32'hFFFF_FFF3, dn);
        e = expect_pack(model[1], model[3], 3);
        model[8] = e;
        chk("R4 done reg variant", {31'b0, dn}, 32'd1);
        rd(4'd8, v); chk("R4 reg amount low4", v, e);
    endtask

    task automatic t_dst0;
        logic dn; logic [31:0] v;
        issue(mk(OPC_I, 4'd0, 4'd1, 4'd2, 3'd0, 5'd4), 32'h0, dn);
        chk("R8 done for dst0", {31'b0, dn}, 32'd1);
        rd(4'd0, v); chk("R8 entry0 stays zero", v, 32'd0);
        rd(4'd4, v); chk("R8 entry4 untouched", v, model[4]);
    endtask

    task automatic t_nomatch;
        logic dn; logic [31:0] v;
        issue(mk(6'h33, 4'd9, 4'd1, 4'd2, 3'd0, 5'd2), 32'h0, dn);
        chk("R9 other opcode no done", {31'b0, dn}, 32'd0);
        rd(4'd9, v); chk("R9 other opcode no write", v, 32'd0);
        issue(mk(OPC_P, 4'd9, 4'd1, 4'd2, 3'd1, 5'd2), 32'h1, dn);
        chk("R9 pool minor1 no done", {31'b0, dn}, 32'd0);
        rd(4'd9, v); chk("R9 pool minor1 no write", v, 32'd0);
        @(negedge clk);
        instr = mk(OPC_I, 4'd9, 4'd1, 4'd2, 3'd0, 5'd2); instr_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 no strobe no done", {31'b0, done}, 32'd0);
        rd(4'd9, v); chk("R9 no strobe no write", v, 32'd0);
    endtask

    task automatic t_collide;
        logic [31:0] v, e;
        @(negedge clk);
        instr = mk(OPC_I, 4'd6, 4'd1, 4'd2, 3'd0, 5'd2); instr_valid = 1'b1;
        wb_en = 1'b1; wb_idx = 4'd6; wb_data = 32'h1111_2222;
        @(posedge clk); @(negedge clk);
        instr_valid = 1'b0; wb_en = 1'b0;
        e = expect_pack(model[1], model[2], 1);
        model[6] = e;
        rd(4'd6, v); chk("R10 unit wins collision", v, e);
    endtask

    task automatic t_self;
        logic dn; logic [31:0] v, e;
        issue(mk(OPC_I, 4'd1, 4'd1, 4'd1, 3'd0, 5'd8), 32'h0, dn);
        e = expect_pack(model[1], model[1], 4);
        model[1] = e;
        rd(4'd1, v); chk("R11 dst equals src old value", v, e);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_imm();
        t_reg();
        t_dst0();
        t_nomatch();
        t_collide();
        t_self();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule